// File: doc/BRIEF.md
# Multi-Mode Timer Output Compare Unit

This unit watches a count supplied by an external free-running timer and compares it against two programmable values, a primary and a secondary. From these matches it drives a single output pin according to one of eight behaviours selected by a 3-bit mode field. The modes are: pass-through of a general-purpose level, single pulses with rising or falling action, toggling, a one-time delayed pulse, a repeating pulse, and pulse-width modulation with or without a fault shutdown input.

A simple write port loads the mode and both compare values. In the PWM modes the primary value is the period. When the count reaches it, the unit raises a timer-reset request. The secondary value is a buffered duty setting that takes effect at each period boundary. A one-cycle interrupt pulse reports the pin edge or fault event that the current mode designates.

Top module: `ocmp_unit`

## Requirements
- R1: After reset the internal pin level is 0, `cmp_irq` and `tmr_rst_req` are 0, and the mode is 000. In that state `pin_out` equals `gpio_val`.
- R2: In mode 000 `pin_out` follows `gpio_val` combinationally, and `cmp_irq` stays 0.
- R3: Mode 001 starts the pin at 0. The first cycle with `tmr_cnt` equal to the primary value sets it to 1 at that clock edge, with a one-cycle `cmp_irq`. Later primary matches have no effect until the mode is written again.
- R4: Mode 010 starts the pin at 1. The first primary match clears it, with a one-cycle `cmp_irq`. Later matches have no effect.
- R5: Mode 011 keeps the level present on `pin_out` when the mode is entered. Each primary match inverts the pin and pulses `cmp_irq`.
- R6: Mode 100 starts the pin at 0. A primary match sets it. A secondary match while high clears it and pulses `cmp_irq`. After that the pin stays 0 until the mode is rewritten.
- R7: Mode 101 behaves like mode 100 but repeats indefinitely. The pin is set on every primary match and cleared on every secondary match, with `cmp_irq` on each fall.
- R8: On entry to modes 110 and 111 the pin is 1 if the primary value is non-zero and 0 otherwise. `tmr_rst_req` is high in any cycle where the mode is 110 or 111 and `tmr_cnt` equals the primary (period) value. At that edge the secondary value is copied into the active duty. The pin becomes 1 if the copied value is non-zero and 0 if it is zero. A later match of `tmr_cnt` with the active duty clears the pin. Mode 110 never pulses `cmp_irq`.
- R9: In mode 111 a high `fault_in` forces the pin to 0 from the next edge and sets a latch. The latch keeps the pin at 0 after `fault_in` returns low. `cmp_irq` pulses for one cycle after the edge at which `fault_in` is first seen low following a high.
- R10: A mode write clears the single-pulse-done state and the fault latch. It also loads the new mode's starting pin level at the same clock edge that captures the write.
- R11: A write with `wr_en` high stores `wr_data` at the clock edge. `wr_sel` 0 selects the mode (bits 2:0), 1 selects the primary value and 2 selects the secondary value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_cnt | input | W | Count from the external timer |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 mode, 1 primary, 2 secondary |
| wr_data | input | W | Write data |
| gpio_val | input | 1 | Level driven on the pin when the unit is disabled |
| fault_in | input | 1 | Active-high fault input, used in mode 111 |
| pin_out | output | 1 | Compare output pin |
| cmp_irq | output | 1 | One-cycle interrupt pulse |
| tmr_rst_req | output | 1 | Timer-reset request on PWM period match |

## Verification
Most of the state in this unit shows on `pin_out` one edge after the timer value that should act on it. A stale single-pulse-done flag or fault latch only shows on a later match, when the pin moves, or fails to move, where the mode rules say otherwise. A wrong active duty shows one full period late, because the buffered value is adopted only at the period boundary. The stimulus therefore revisits matches after each one-shot event and spans two PWM periods after every duty change.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

  typedef enum logic [2:0] {
    OC_OFF       = 3'd0,
    OC_LOW1SHOT  = 3'd1,
    OC_HIGH1SHOT = 3'd2,
    OC_TOGGLE    = 3'd3,
    OC_DLY1SHOT  = 3'd4,
    OC_CONTPULSE = 3'd5,
    OC_PWM       = 3'd6,
    OC_PWM_FLT   = 3'd7
  } ocm_e;

  // True for both pulse-width modes.
  function automatic logic is_pwm(input ocm_e m);
    return (m == OC_PWM) || (m == OC_PWM_FLT);
  endfunction

  // Pin level loaded when a mode is entered.
  function automatic logic entry_level(input ocm_e m, input logic pri_nz,
                                       input logic cur);
    case (m)
      OC_HIGH1SHOT:      return 1'b1;
      OC_TOGGLE:         return cur;
      OC_PWM, OC_PWM_FLT: return pri_nz;
      default:           return 1'b0;
    endcase
  endfunction

  // Whether a pin transition from old_l to new_l raises the interrupt.
  function automatic logic edge_irq(input ocm_e m, input logic old_l,
                                    input logic new_l);
    logic rise, fall;
    rise = !old_l && new_l;
    fall = old_l && !new_l;
    case (m)
      OC_LOW1SHOT:                return rise;
      OC_HIGH1SHOT:               return fall;
      OC_TOGGLE:                  return rise || fall;
      OC_DLY1SHOT, OC_CONTPULSE:  return fall;
      default:                    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ocmp_regs.sv
module ocmp_regs
  import ocmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         per_load,
  output ocm_e         mode_q,
  output logic [W-1:0] pri_q,
  output logic [W-1:0] sec_q,
  output logic [W-1:0] duty_q,
  output logic         mode_wr
);

  localparam logic [1:0] SEL_MODE = 2'd0;
  localparam logic [1:0] SEL_PRI  = 2'd1;
  localparam logic [1:0] SEL_SEC  = 2'd2;

  assign mode_wr = wr_en && (wr_sel == SEL_MODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= OC_OFF;
      pri_q  <= '0;
      sec_q  <= '0;
      duty_q <= '0;
    end else begin
      if (mode_wr) mode_q <= ocm_e'(wr_data[2:0]);
      if (wr_en && wr_sel == SEL_PRI) pri_q <= wr_data;
      if (wr_en && wr_sel == SEL_SEC) sec_q <= wr_data;
      // Active duty adopts the buffered value on mode entry and period match.
      if (mode_wr || per_load) duty_q <= sec_q;
    end
  end

  // Active duty changes only on a mode write or a period load.
  AST_DUTY_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_wr && !per_load) |=> $stable(duty_q)); // R8

endmodule

// File: rtl/ocmp_match.sv
module ocmp_match #(
  parameter int W = 8,
  parameter int N = 3
) (
  input  logic [W-1:0]        tmr_cnt,
  input  logic [N-1:0][W-1:0] refs,
  output logic [N-1:0]        hits
);

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hits[i] = (tmr_cnt == refs[i]);
  end

endmodule

// File: rtl/ocmp_core.sv
module ocmp_core
  import ocmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ocm_e         mode_q,
  input  logic         mode_wr,
  input  ocm_e         new_mode,
  input  logic [W-1:0] pri_val,
  input  logic [W-1:0] sec_val,
  input  logic         pri_hit,
  input  logic         sec_hit,
  input  logic         duty_hit,
  input  logic         gpio_val,
  input  logic         fault_in,
  output logic         pin_q,
  output logic         irq_q
);

  logic done_q, flt_q, fault_d;
  logic pin_n, done_n, flt_n, irq_n;
  logic cur_level;
  logic fault_fall;

  assign cur_level  = (mode_q == OC_OFF) ? gpio_val : pin_q;
  assign fault_fall = fault_d && !fault_in;

  always_comb begin
    pin_n  = pin_q;
    done_n = done_q;
    flt_n  = flt_q;
    irq_n  = 1'b0;
    if (mode_wr) begin
      pin_n  = entry_level(new_mode, pri_val != '0, cur_level);
      done_n = 1'b0;
      flt_n  = 1'b0;
    end else begin
      case (mode_q)
        OC_LOW1SHOT: if (!done_q && pri_hit) begin
          pin_n  = 1'b1;
          done_n = 1'b1;
        end
        OC_HIGH1SHOT: if (!done_q && pri_hit) begin
          pin_n  = 1'b0;
          done_n = 1'b1;
        end
        OC_TOGGLE: if (pri_hit) pin_n = !pin_q;
        OC_DLY1SHOT: if (!done_q) begin
          if (sec_hit && pin_q) begin
            pin_n  = 1'b0;
            done_n = 1'b1;
          end else if (pri_hit) begin
            pin_n = 1'b1;
          end
        end
        OC_CONTPULSE: begin
          if (sec_hit && pin_q) pin_n = 1'b0;
          else if (pri_hit)     pin_n = 1'b1;
        end
        OC_PWM, OC_PWM_FLT: begin
          if (pri_hit)       pin_n = (sec_val != '0);
          else if (duty_hit) pin_n = 1'b0;
          if (mode_q == OC_PWM_FLT && (fault_in || flt_q)) begin
            flt_n = 1'b1;
            pin_n = 1'b0;
          end
        end
        default: ;
      endcase
      irq_n = edge_irq(mode_q, pin_q, pin_n) ||
              (mode_q == OC_PWM_FLT && fault_fall);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q   <= 1'b0;
      done_q  <= 1'b0;
      flt_q   <= 1'b0;
      fault_d <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      pin_q   <= pin_n;
      done_q  <= done_n;
      flt_q   <= flt_n;
      fault_d <= fault_in;
      irq_q   <= irq_n;
    end
  end

  AST_ONESHOT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == OC_LOW1SHOT && pin_q && !mode_wr) |=> pin_q); // R3

  AST_HIGH_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && new_mode == OC_HIGH1SHOT) |=> pin_q); // R4

  AST_DELAYED_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == OC_DLY1SHOT && done_q && !mode_wr) |=> !pin_q); // R6

  AST_NO_IRQ_PLAIN_PWM: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == OC_PWM && !mode_wr) |=> !irq_q); // R8

  AST_FAULT_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == OC_PWM_FLT && (fault_in || flt_q) && !mode_wr) |=> !pin_q); // R9

  AST_WRITE_CLEARS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (!flt_q && !done_q)); // R10

endmodule

// File: rtl/ocmp_unit.sv
module ocmp_unit
  import ocmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tmr_cnt,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         gpio_val,
  input  logic         fault_in,
  output logic         pin_out,
  output logic         cmp_irq,
  output logic         tmr_rst_req
);

  localparam int NREF    = 3;
  localparam int IDX_PRI = 0;
  localparam int IDX_SEC = 1;
  localparam int IDX_DTY = 2;

  ocm_e                    mode_q;
  logic [W-1:0]            pri_q, sec_q, duty_q;
  logic                    mode_wr;
  logic                    per_load;
  logic [NREF-1:0][W-1:0]  refs;
  logic [NREF-1:0]         hits;
  logic                    pin_q;
  logic                    period_match;

  assign refs[IDX_PRI] = pri_q;
  assign refs[IDX_SEC] = sec_q;
  assign refs[IDX_DTY] = duty_q;

  assign period_match = is_pwm(mode_q) && hits[IDX_PRI];
  assign per_load     = period_match && !mode_wr;

  ocmp_regs #(.W(W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .per_load(per_load),
    .mode_q  (mode_q),
    .pri_q   (pri_q),
    .sec_q   (sec_q),
    .duty_q  (duty_q),
    .mode_wr (mode_wr)
  );

  ocmp_match #(.W(W), .N(NREF)) u_match (
    .tmr_cnt(tmr_cnt),
    .refs   (refs),
    .hits   (hits)
  );

  ocmp_core #(.W(W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_q  (mode_q),
    .mode_wr (mode_wr),
    .new_mode(ocm_e'(wr_data[2:0])),
    .pri_val (pri_q),
    .sec_val (sec_q),
    .pri_hit (hits[IDX_PRI]),
    .sec_hit (hits[IDX_SEC]),
    .duty_hit(hits[IDX_DTY]),
    .gpio_val(gpio_val),
    .fault_in(fault_in),
    .pin_q   (pin_q),
    .irq_q   (cmp_irq)
  );

  assign pin_out     = (mode_q == OC_OFF) ? gpio_val : pin_q;
  assign tmr_rst_req = period_match;

  AST_OFF_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == OC_OFF && !mode_wr) |=> !cmp_irq); // R2

  AST_RST_REQ_PWM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_rst_req |-> (tmr_cnt == pri_q)); // R8

endmodule

// File: tb/ocmp_unit_bench.sv
`timescale 1ns/1ps
module ocmp_unit_bench;

  localparam int W = 8;
  localparam logic [W-1:0] IDLE = 8'hF0;
  // Row: op[15:14] (0 mode,1 pri,2 sec,3 timer), data[13:6], pin[5], irq[4], req[3:0]
  localparam int NV = 46;
  localparam logic [15:0] VEC [NV] = '{
    {2'd1, 8'd5, 1'b0, 1'b0, 4'd11}, // R11 primary write, mode 000
    {2'd0, 8'd1, 1'b0, 1'b0, 4'd3},  // R3 entry 0
    {2'd3, 8'd4, 1'b0, 1'b0, 4'd3},
    {2'd3, 8'd5, 1'b1, 1'b1, 4'd3},  // R3 rise + irq
    {2'd3, 8'd6, 1'b1, 1'b0, 4'd3},
    {2'd3, 8'd5, 1'b1, 1'b0, 4'd3},  // R3 second match ignored
    {2'd0, 8'd2, 1'b1, 1'b0, 4'd4},  // R4 entry 1
    {2'd3, 8'd5, 1'b0, 1'b1, 4'd4},  // R4 fall + irq
    {2'd3, 8'd5, 1'b0, 1'b0, 4'd4},  // R4 second match ignored
    {2'd0, 8'd3, 1'b0, 1'b0, 4'd5},  // R5 keeps 0
    {2'd3, 8'd5, 1'b1, 1'b1, 4'd5},
    {2'd3, 8'd6, 1'b1, 1'b0, 4'd5},
    {2'd3, 8'd5, 1'b0, 1'b1, 4'd5},
    {2'd2, 8'd8, 1'b0, 1'b0, 4'd11}, // R11 secondary write
    {2'd0, 8'd4, 1'b0, 1'b0, 4'd6},  // R6 entry 0
    {2'd3, 8'd5, 1'b1, 1'b0, 4'd6},
    {2'd3, 8'd6, 1'b1, 1'b0, 4'd6},
    {2'd3, 8'd8, 1'b0, 1'b1, 4'd6},
    {2'd3, 8'd5, 1'b0, 1'b0, 4'd6},  // R6 stays low
    {2'd3, 8'd8, 1'b0, 1'b0, 4'd6},
    {2'd0, 8'd5, 1'b0, 1'b0, 4'd10}, // R10 done cleared
    {2'd3, 8'd5, 1'b1, 1'b0, 4'd7},
    {2'd3, 8'd8, 1'b0, 1'b1, 4'd7},
    {2'd3, 8'd5, 1'b1, 1'b0, 4'd7},  // R7 repeats
    {2'd3, 8'd8, 1'b0, 1'b1, 4'd7},
    {2'd1, 8'd4, 1'b0, 1'b0, 4'd11},
    {2'd2, 8'd2, 1'b0, 1'b0, 4'd11},
    {2'd0, 8'd6, 1'b1, 1'b0, 4'd8},  // R8 entry 1, primary non-zero
    {2'd3, 8'd0, 1'b1, 1'b0, 4'd8},
    {2'd3, 8'd1, 1'b1, 1'b0, 4'd8},
    {2'd3, 8'd2, 1'b0, 1'b0, 4'd8},  // R8 duty match
    {2'd3, 8'd3, 1'b0, 1'b0, 4'd8},
    {2'd3, 8'd4, 1'b1, 1'b0, 4'd8},  // R8 period start, no irq
    {2'd3, 8'd0, 1'b1, 1'b0, 4'd8},
    {2'd3, 8'd1, 1'b1, 1'b0, 4'd8},
    {2'd3, 8'd2, 1'b0, 1'b0, 4'd8},
    {2'd2, 8'd0, 1'b0, 1'b0, 4'd8},  // R8 buffered zero duty
    {2'd3, 8'd3, 1'b0, 1'b0, 4'd8},
    {2'd3, 8'd4, 1'b0, 1'b0, 4'd8},  // R8 zero duty keeps low
    {2'd3, 8'd0, 1'b0, 1'b0, 4'd8},
    {2'd3, 8'd1, 1'b0, 1'b0, 4'd8},
    {2'd0, 8'd2, 1'b1, 1'b0, 4'd4},
    {2'd0, 8'd3, 1'b1, 1'b0, 4'd5},  // R5 keeps 1
    {2'd3, 8'd4, 1'b0, 1'b1, 4'd5},
    {2'd3, 8'd6, 1'b0, 1'b0, 4'd5},
    {2'd3, 8'd4, 1'b1, 1'b1, 4'd5}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] tmr_cnt = IDLE;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic         gpio_val = 1'b0;
  logic         fault_in = 1'b0;
  logic         pin_out, cmp_irq, tmr_rst_req;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = !clk;

  ocmp_unit #(.W(W)) u_ocmp_unit (
    .clk(clk), .rst_n(rst_n), .tmr_cnt(tmr_cnt), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .gpio_val(gpio_val),
    .fault_in(fault_in), .pin_out(pin_out), .cmp_irq(cmp_irq),
    .tmr_rst_req(tmr_rst_req)
  );

  task automatic chk(input logic got, input logic exp, input string req,
                     input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  // One cycle of stimulus; returns 1 ns after the capturing edge.
  task automatic step(input logic [1:0] op, input logic [W-1:0] d);
    if (op == 2'd3) begin
      wr_en = 1'b0; tmr_cnt = d;
    end else begin
      wr_en = 1'b1; wr_sel = op; wr_data = d; tmr_cnt = IDLE;
    end
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  initial begin
    #100000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    string rq;
    #12;
    // R1 reset state
    chk(cmp_irq, 1'b0, "R1", "irq in reset");
    chk(tmr_rst_req, 1'b0, "R1", "rst_req in reset");
    gpio_val = 1'b1; #1;
    chk(pin_out, 1'b1, "R1", "pin follows gpio in reset");
    gpio_val = 1'b0;
    @(posedge clk); #1; rst_n = 1'b1;
    @(posedge clk); #1;
    // R2 pass-through in mode 000
    gpio_val = 1'b1; step(2'd3, 8'd0);
    chk(pin_out, 1'b1, "R2", "gpio high");
    chk(cmp_irq, 1'b0, "R2", "no irq");
    gpio_val = 1'b0; #1;
    chk(pin_out, 1'b0, "R2", "gpio low");

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][15:14], VEC[i][13:6]);
      rq = $sformatf("R%0d", VEC[i][3:0]);
      chk(pin_out, VEC[i][5], rq, $sformatf("vector %0d pin", i));
      chk(cmp_irq, VEC[i][4], rq, $sformatf("vector %0d irq", i));
    end

    // R8 timer-reset request: primary=4, secondary=0 from table; mode 011 now
    tmr_cnt = 8'd4; #1;
    chk(tmr_rst_req, 1'b0, "R8", "no request outside PWM");
    step(2'd2, 8'd2);
    step(2'd0, 8'd7);
    chk(pin_out, 1'b1, "R10", "PWM fault mode entry high");
    tmr_cnt = 8'd4; #1;
    chk(tmr_rst_req, 1'b1, "R8", "request on period match");
    tmr_cnt = 8'd3; #1;
    chk(tmr_rst_req, 1'b0, "R8", "no request off period");

    // R9 fault shutdown and latch
    fault_in = 1'b1; step(2'd3, 8'd0);
    chk(pin_out, 1'b0, "R9", "fault forces low");
    chk(cmp_irq, 1'b0, "R9", "no irq while fault high");
    fault_in = 1'b0; step(2'd3, 8'd1);
    chk(cmp_irq, 1'b1, "R9", "irq on fault fall");
    chk(pin_out, 1'b0, "R9", "latched low");
    step(2'd3, 8'd4);
    chk(pin_out, 1'b0, "R9", "latch holds through period");
    chk(cmp_irq, 1'b0, "R9", "single irq pulse");
    // R10 rewrite clears the latch
    step(2'd0, 8'd7);
    chk(pin_out, 1'b1, "R10", "latch cleared by mode write");
    step(2'd3, 8'd4);
    chk(pin_out, 1'b1, "R10", "period start after clear");
    step(2'd3, 8'd2);
    chk(pin_out, 1'b0, "R8", "duty match in fault mode");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule